// File: doc/BRIEF.md
# Combined 2D Subband Scaling Unit

This unit finishes a separable two-dimensional 9/7 wavelet transform whose horizontal and vertical one-dimensional lifting passes both skip their final normalisation. Instead of scaling every coefficient twice, once per pass, the unit applies one merged gain to each coefficient after both passes are done. The gain depends only on the subband the coefficient belongs to.

Coefficients arrive on a valid/data interface with two lanes per cycle. Each lane carries its own two-bit subband tag. Low-low coefficients are multiplied by the square of the lifting normalisation constant. High-high coefficients are multiplied by the reciprocal of that square. The two mixed subbands already have unit gain, so they are not multiplied at all. They are only delayed, so that they leave the unit in step with the multiplied lanes.

Products are rounded to nearest and clamped to the coefficient width. Every beat leaves the unit a fixed two cycles after it enters, with its tags unchanged. The upstream passes must therefore leave out their own gain steps.

Top module: `subscale_top`

## Requirements
- R1: While reset is high, and in the cycle after it, out_valid is 0 and out_coef is all zeros.
- R2: A beat presented with in_valid high at a rising edge appears at the outputs with out_valid high exactly two rising edges later. Beats keep their order. A cycle with in_valid low produces no output beat.
- R3: Each lane's subband tag comes out unchanged on out_band, in the same beat as that lane's coefficient.
- R4: Lanes tagged 2'b01 (low-high) or 2'b10 (high-low) output their input coefficient unchanged.
- R5: Lanes tagged 2'b00 (low-low) output floor((c*24794 + 8192) / 16384). The constant 24794 is k squared with 14 fractional bits, for k = 1.230174.
- R6: Lanes tagged 2'b11 (high-high) output floor((c*10826 + 8192) / 16384). The constant 10826 is 1/k squared with 14 fractional bits.
- R7: A scaled result outside the signed COEF_W range is clamped to the nearest limit (32767 or -32768 for COEF_W = 16).
- R8: The two lanes are processed independently within a beat. Lane i uses bits [2i+1:2i] of the band fields and bits [COEF_W*(i+1)-1:COEF_W*i] of the coefficient fields.
- R9: While out_valid is 0, out_coef and out_band hold their last values. Data presented with in_valid low does not reach them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat qualifier |
| in_band | input | 2*LANES | Per-lane subband tag (00 LL, 01 LH, 10 HL, 11 HH) |
| in_coef | input | COEF_W*LANES | Per-lane signed input coefficient |
| out_valid | output | 1 | Output beat qualifier |
| out_band | output | 2*LANES | Per-lane subband tag, delayed with the data |
| out_coef | output | COEF_W*LANES | Per-lane scaled signed coefficient |

## Verification
Directed beats put the extremes of the coefficient range on low-low lanes. These separate correct clamping (R7) from wraparound, and the same values on high-high lanes confirm that no clamping takes place there. Beats with mixed tags across the two lanes catch a shared or swapped gain select (R8), and show that the low-high and high-low tags bypass the multiplier. Long random streams cover every tag with random signed values. Random idle gaps, carrying junk on the data inputs, expose any rounding offset, any error in the latency of two, and any output that moves while out_valid is low (R9).

// File: rtl/subscale_pkg.sv
package subscale_pkg;

    typedef enum logic [1:0] {
        BAND_LL = 2'b00,
        BAND_LH = 2'b01,
        BAND_HL = 2'b10,
        BAND_HH = 2'b11
    } band_e;

    // fixed-point format of the merged gains
    localparam int GAIN_FRAC = 14;
    localparam int GAIN_W    = GAIN_FRAC + 3;   // signed, room for gains below 4

    // k*k and 1/(k*k) for k = 1.230174, 14 fractional bits
    localparam logic signed [GAIN_W-1:0] GAIN_LOWLOW   = 17'sd24794;
    localparam logic signed [GAIN_W-1:0] GAIN_HIGHHIGH = 17'sd10826;

    typedef struct packed {
        logic                      scale_en;
        logic signed [GAIN_W-1:0]  gain;
    } gain_sel_t;

    function automatic gain_sel_t pick_gain(input band_e b);
        gain_sel_t s;
        s.scale_en = 1'b0;
        s.gain     = '0;
        case (b)
            BAND_LL: begin s.scale_en = 1'b1; s.gain = GAIN_LOWLOW;   end
            BAND_HH: begin s.scale_en = 1'b1; s.gain = GAIN_HIGHHIGH; end
            default: begin s.scale_en = 1'b0; s.gain = '0;            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/subscale_band_decode.sv
module subscale_band_decode
    import subscale_pkg::*;
(
    input  logic [1:0] band,
    output gain_sel_t  sel
);
    always_comb begin
        sel = pick_gain(band_e'(band));
    end
endmodule

// File: rtl/subscale_lane_mult.sv
module subscale_lane_mult
    import subscale_pkg::*;
#(
    parameter int COEF_W = 16,
    localparam int PROD_W = COEF_W + GAIN_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [1:0]               band,
    input  logic signed [COEF_W-1:0] coef,
    input  gain_sel_t                sel,
    output logic signed [PROD_W-1:0] prod_q,
    output logic signed [COEF_W-1:0] coef_q,
    output logic                     scale_q,
    output logic [1:0]               band_q
);
    logic signed [PROD_W-1:0] prod_d;

    always_comb begin
        prod_d = PROD_W'(coef) * PROD_W'(sel.gain);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            coef_q  <= '0;
            scale_q <= 1'b0;
            band_q  <= '0;
        end else if (en) begin
            prod_q  <= prod_d;
            coef_q  <= coef;
            scale_q <= sel.scale_en;
            band_q  <= band;
        end
    end
endmodule

// File: rtl/subscale_lane_round.sv
module subscale_lane_round
    import subscale_pkg::*;
#(
    parameter int COEF_W = 16,
    localparam int PROD_W = COEF_W + GAIN_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [PROD_W-1:0] prod,
    input  logic signed [COEF_W-1:0] coef,
    input  logic                     scale,
    input  logic [1:0]               band,
    output logic signed [COEF_W-1:0] res_q,
    output logic [1:0]               band_q
);
    localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (GAIN_FRAC - 1);
    localparam logic signed [PROD_W-1:0] LIM_HI   = PROD_W'((longint'(1) <<< (COEF_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] LIM_LO   = -(PROD_W'(1) <<< (COEF_W - 1));

    logic signed [PROD_W-1:0] rounded;
    logic signed [COEF_W-1:0] clamped;
    logic signed [COEF_W-1:0] res_d;

    always_comb begin
        rounded = (prod + HALF_LSB) >>> GAIN_FRAC;
        if (rounded > LIM_HI)
            clamped = LIM_HI[COEF_W-1:0];
        else if (rounded < LIM_LO)
            clamped = LIM_LO[COEF_W-1:0];
        else
            clamped = rounded[COEF_W-1:0];
        res_d = scale ? clamped : coef;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            band_q <= '0;
        end else if (en) begin
            res_q  <= res_d;
            band_q <= band;
        end
    end
endmodule

// File: rtl/subscale_top.sv
module subscale_top
    import subscale_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [2*LANES-1:0]        in_band,
    input  logic [COEF_W*LANES-1:0]   in_coef,
    output logic                      out_valid,
    output logic [2*LANES-1:0]        out_band,
    output logic [COEF_W*LANES-1:0]   out_coef
);
    localparam int PROD_W = COEF_W + GAIN_W;

    logic mid_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_valid <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            mid_valid <= in_valid;
            out_valid <= mid_valid;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        gain_sel_t                sel;
        logic signed [PROD_W-1:0] prod_m;
        logic signed [COEF_W-1:0] coef_m;
        logic                     scale_m;
        logic [1:0]               band_m;
        logic signed [COEF_W-1:0] res;
        logic [1:0]               band_o;

        subscale_band_decode u_dec (
            .band (in_band[2*l +: 2]),
            .sel  (sel)
        );

        subscale_lane_mult #(.COEF_W(COEF_W)) u_mult (
            .clk     (clk),
            .rst     (rst),
            .en      (in_valid),
            .band    (in_band[2*l +: 2]),
            .coef    (in_coef[COEF_W*l +: COEF_W]),
            .sel     (sel),
            .prod_q  (prod_m),
            .coef_q  (coef_m),
            .scale_q (scale_m),
            .band_q  (band_m)
        );

        subscale_lane_round #(.COEF_W(COEF_W)) u_round (
            .clk    (clk),
            .rst    (rst),
            .en     (mid_valid),
            .prod   (prod_m),
            .coef   (coef_m),
            .scale  (scale_m),
            .band   (band_m),
            .res_q  (res),
            .band_q (band_o)
        );

        assign out_coef[COEF_W*l +: COEF_W] = res;
        assign out_band[2*l +: 2]           = band_o;
    end
endmodule

// File: rtl/subscale_chk.sv
module subscale_chk #(
    parameter int COEF_W = 16,
    parameter int LANES  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [2*LANES-1:0]      in_band,
    input logic [COEF_W*LANES-1:0] in_coef,
    input logic                    out_valid,
    input logic [2*LANES-1:0]      out_band,
    input logic [COEF_W*LANES-1:0] out_coef
);
    function automatic int mag(input logic signed [COEF_W-1:0] v);
        int x;
        x = int'(v);
        return (x < 0) ? -x : x;
    endfunction

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_coef == '0));

    a_r2_beat_out: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    a_r2_no_beat: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_coef) && $stable(out_band)));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        a_r3_tag_kept: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> ##2 (out_band[2*l +: 2] == $past(in_band[2*l +: 2], 2)));

        a_r4_mixed_pass: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (in_band[2*l +: 2] == 2'b01 || in_band[2*l +: 2] == 2'b10))
            |-> ##2 (out_coef[COEF_W*l +: COEF_W] == $past(in_coef[COEF_W*l +: COEF_W], 2)));

        a_r6_hh_no_growth: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_band[2*l +: 2] == 2'b11)
            |-> ##2 (mag(out_coef[COEF_W*l +: COEF_W]) <= mag($past(in_coef[COEF_W*l +: COEF_W], 2))));

        a_r7_ll_sign: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_band[2*l +: 2] == 2'b00 && in_coef[COEF_W*(l+1)-1])
            |-> ##2 out_coef[COEF_W*(l+1)-1]);
    end
endmodule

bind subscale_top subscale_chk #(.COEF_W(COEF_W), .LANES(LANES)) u_chk (.*);

// File: tb/tb_subscale_top.sv
module tb_subscale_top;
    localparam int W     = 16;
    localparam int LANES = 2;
    localparam int WD_CYCLES = 150000;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic [2*LANES-1:0]     in_band = '0;
    logic [W*LANES-1:0]     in_coef = '0;
    logic                   out_valid;
    logic [2*LANES-1:0]     out_band;
    logic [W*LANES-1:0]     out_coef;

    int checks = 0;
    int fails  = 0;
    int tick   = 0;
    bit running = 1'b0;
    bit done    = 1'b0;

    logic [2*LANES-1:0] q_band[$];
    logic [W*LANES-1:0] q_coef[$];
    int                 q_due[$];

    logic [2*LANES-1:0] last_band = '0;
    logic [W*LANES-1:0] last_coef = '0;

    subscale_top #(.COEF_W(W), .LANES(LANES)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_band(in_band),
        .in_coef(in_coef), .out_valid(out_valid), .out_band(out_band),
        .out_coef(out_coef)
    );

    always #5 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    function automatic logic signed [W-1:0] model(input logic [1:0] b, input logic signed [W-1:0] c);
        longint p;
        longint r;
        if (b == 2'b01 || b == 2'b10) return c;       // R4
        p = longint'(c) * ((b == 2'b00) ? 24794 : 10826);  // R5 / R6
        r = (p + 8192) >>> 14;
        if (r > 32767)  r = 32767;                     // R7
        if (r < -32768) r = -32768;
        return W'(r);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [2*LANES-1:0] b, input logic [W*LANES-1:0] c);
        logic [W*LANES-1:0] e;
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_band  = b;
        in_coef  = c;
        for (int l = 0; l < LANES; l++)
            e[W*l +: W] = model(b[2*l +: 2], c[W*l +: W]);
        q_band.push_back(b);
        q_coef.push_back(e);
        q_due.push_back(tick + 2);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b0;
            in_band  = 4'($urandom);
            in_coef  = 32'($urandom);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (running && !rst) begin
            if (q_due.size() > 0 && q_due[0] == tick) begin
                check(out_valid == 1'b1, "R2 beat present", out_valid, 1);
                for (int l = 0; l < LANES; l++) begin
                    logic [1:0] eb;
                    logic signed [W-1:0] ec;
                    logic signed [W-1:0] ac;
                    string tag;
                    eb = q_band[0][2*l +: 2];
                    ec = q_coef[0][W*l +: W];
                    ac = out_coef[W*l +: W];
                    if (eb == 2'b01 || eb == 2'b10) tag = "R4 mixed pass";
                    else if (ec == 16'sh7fff || ec == -16'sh8000) tag = "R7 clamp";
                    else if (eb == 2'b00) tag = "R5 low-low gain";
                    else tag = "R6 high-high gain";
                    check(out_band[2*l +: 2] == eb, "R3 tag (R8 lane)", out_band[2*l +: 2], eb);
                    check(ac == ec, tag, ac, ec);
                end
                void'(q_band.pop_front());
                void'(q_coef.pop_front());
                void'(q_due.pop_front());
            end else begin
                check(out_valid == 1'b0, "R2 no beat", out_valid, 0);
                check(out_coef == last_coef, "R9 hold coef", out_coef, last_coef);
                check(out_band == last_band, "R9 hold band", out_band, last_band);
            end
            last_coef = out_coef;
            last_band = out_band;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        check(out_coef == '0, "R1 reset coef", out_coef, 0);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_coef == '0, "R1 after reset", out_coef, 0);
        running = 1'b1;

        // directed: extremes, mixed tags across lanes (R5 R6 R7 R8 R4)
        send({2'b00, 2'b00}, {16'sh7fff, -16'sh8000});
        send({2'b11, 2'b11}, {16'sh7fff, -16'sh8000});
        send({2'b01, 2'b10}, {16'sh1234, -16'sd77});
        send({2'b11, 2'b00}, {16'sd1000, 16'sd1000});
        send({2'b00, 2'b11}, {-16'sd1, 16'sd1});
        send({2'b10, 2'b00}, {16'sd0, 16'sd21651});
        idle(3);
        send({2'b00, 2'b01}, {16'sd21652, 16'sd5});
        idle(1);

        // random stream with random gaps
        for (int i = 0; i < 3000; i++) begin
            send(4'($urandom), 32'($urandom));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(5);
        check(q_due.size() == 0, "R2 all beats out", q_due.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule